// File: doc/BRIEF.md
# Two-Channel Serial ADC Frame Sequencer

This block sits in a host chip and runs a two-input, 12-bit successive-approximation converter over a three-wire serial link: an active-low select line, a serial clock it generates from the system clock, and a channel-select line. It also receives the converter's serial data line. A request carries a channel number, a frame-length choice (full 16-cycle frame or short 14-cycle frame) and a flag asking that the converter be put to sleep once the conversion is done. The block answers with a 12-bit result, a one-cycle valid strobe, the channel it belongs to and a flag that reports a bad leading bit.

The converter picks up the channel-select level during one frame and uses it for the frame after. The converter also needs one throw-away frame to wake up. For this reason the sequencer keeps track of the converter's power state and of the channel the converter will sample next. When the converter is asleep, or when the requested channel differs from the one it has latched, the block first runs a full 16-cycle frame and discards its data. During that frame it moves the channel-select line. A sleep request adds a short frame after the conversion. That short frame raises the select line after the 4th serial clock cycle, which powers the converter down, and it produces no result.

The serial clock half-period, the delay from the select falling edge to the first clock edge, and the select-high time between frames are run-time inputs counted in system-clock cycles.

Top module: `adc_frame_sequencer`

## Requirements
- R1: After reset, and whenever `adc_cs_n` is high, `adc_sclk` is high. After reset `res_valid` is 0 and `req_ready` is 1.
- R2: The block captures `adc_dout` when `adc_sclk` rises. Counting rising edges from 1 within a frame, edges 2 to 13 carry result bits 11 down to 0, MSB first, and they form `res_data`.
- R3: `res_valid` is high for exactly one system cycle, in the cycle where `adc_cs_n` rises at the end of a conversion frame. `res_chan` holds the requested channel in that cycle.
- R4: `res_flag` is 1 exactly when the bit captured on rising edge 1 of the conversion frame is 1.
- R5: A conversion frame has 16 serial clock cycles when `req_short`=0 and 14 cycles when `req_short`=1. Discarded wake or switch frames always have 16 cycles.
- R6: When `req_sleep`=1, a frame of exactly 4 serial clock cycles follows the conversion. Its select line rises after the 4th rising edge, it produces no result, and the converter is left powered down.
- R7: After reset or after a power-down, the next request is preceded by one 16-cycle frame whose data is discarded.
- R8: `adc_chsel` (0 selects input 1 for channel 0, 1 selects input 2 for channel 1) changes only while `adc_cs_n` is low and the frame is in serial cycles 2 to 12. A request for a channel other than the latched one while the converter is awake is preceded by one discarded 16-cycle frame that sets the line at the 2nd falling edge.
- R9: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each request gives at most one result.
- R10: Each low phase and each high phase of `adc_sclk` inside a frame lasts max(`cfg_half`,1) system cycles. The first falling edge of `adc_sclk` comes max(`cfg_setup`,`cfg_half`,1) cycles after `adc_cs_n` falls.
- R11: Between two frames, `adc_cs_n` stays high for at least max(`cfg_gap`,1) system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_chan | input | 1 | Requested channel (0 or 1) |
| req_short | input | 1 | 1 selects the 14-cycle conversion frame |
| req_sleep | input | 1 | Power the converter down after this conversion |
| cfg_half | input | DIV_W | Serial clock half-period in system cycles |
| cfg_setup | input | DIV_W | Select-fall to first clock edge delay |
| cfg_gap | input | DIV_W | Minimum select-high time between frames |
| adc_dout | input | 1 | Serial data from the converter |
| req_ready | output | 1 | Block idle and able to take a request |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_chsel | output | 1 | Channel select for the next conversion |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Conversion result |
| res_chan | output | 1 | Channel of the result |
| res_flag | output | 1 | Leading bit was not zero |

## Verification
The assertions assume that the three timing inputs hold still while a request is being served. They also assume the converter only changes its data line after a falling serial clock edge, so that each capture sees a settled bit. The stimulus changes the timing inputs only while `req_ready` is high, and then waits longer than any gap before it issues the next request. A behavioural converter model drives the data line on falling clock edges, latches the channel line at the 12th falling edge, and changes its own power state depending on how many cycles each frame had.

// File: rtl/adc_frame_sequencer.sv
module adc_frame_sequencer #(
  parameter int DIV_W  = 8,
  parameter int RES_W  = 12,
  parameter int PD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_chan,
  input  logic             req_short,
  input  logic             req_sleep,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [DIV_W-1:0] cfg_setup,
  input  logic [DIV_W-1:0] cfg_gap,
  input  logic             adc_dout,
  output logic             req_ready,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_chsel,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_chan,
  output logic             res_flag
);
  localparam int FULL_CYC  = RES_W + 4;
  localparam int SHORT_CYC = RES_W + 2;
  localparam int CW        = $clog2(FULL_CYC + 1);
  localparam logic [CW-1:0] LSB_CYC = CW'(RES_W + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_SETUP = 3'd1, S_LOW = 3'd2,
                         S_HIGH = 3'd3, S_GAP = 3'd4;
  localparam logic [1:0] K_DUMMY = 2'd0, K_CONV = 2'd1, K_PD = 2'd2;

  logic [2:0]       st;
  logic [1:0]       kind;
  logic [DIV_W-1:0] tmr;
  logic [CW-1:0]    cyc;
  logic [RES_W:0]   sh;
  logic             awake, more, chan_q, short_q, sleep_q;

  logic [DIV_W-1:0] half_len, setup_len, gap_len;
  logic [CW-1:0]    last_cyc;
  logic             tmr_done;

  assign half_len  = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
  assign setup_len = (cfg_setup > half_len) ? cfg_setup : half_len;
  assign gap_len   = (cfg_gap == '0) ? DIV_W'(1) : cfg_gap;
  assign tmr_done  = (tmr <= DIV_W'(1));
  assign req_ready = (st == S_IDLE);
  assign last_cyc  = (kind == K_PD)   ? CW'(PD_CYC) :
                     (kind == K_CONV && short_q) ? CW'(SHORT_CYC) : CW'(FULL_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_DUMMY; tmr <= '0; cyc <= '0; sh <= '0;
      awake <= 1'b0; more <= 1'b0; chan_q <= 1'b0; short_q <= 1'b0; sleep_q <= 1'b0;
      adc_cs_n <= 1'b1; adc_sclk <= 1'b1; adc_chsel <= 1'b0;
      res_valid <= 1'b0; res_data <= '0; res_chan <= 1'b0; res_flag <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          chan_q   <= req_chan;
          short_q  <= req_short;
          sleep_q  <= req_sleep;
          kind     <= (!awake || req_chan != adc_chsel) ? K_DUMMY : K_CONV;
          adc_cs_n <= 1'b0;
          cyc      <= '0;
          tmr      <= setup_len;
          st       <= S_SETUP;
        end
        S_SETUP: if (tmr_done) begin
          adc_sclk <= 1'b0;
          cyc      <= CW'(1);
          tmr      <= half_len;
          st       <= S_LOW;
        end else tmr <= tmr - 1'b1;
        S_LOW: if (tmr_done) begin
          adc_sclk <= 1'b1;
          tmr      <= half_len;
          st       <= S_HIGH;
          if (cyc <= LSB_CYC) sh <= {sh[RES_W-1:0], adc_dout};
        end else tmr <= tmr - 1'b1;
        S_HIGH: if (tmr_done) begin
          if (cyc == last_cyc) begin
            adc_cs_n <= 1'b1;
            tmr      <= gap_len;
            st       <= S_GAP;
            case (kind)
              K_DUMMY: begin awake <= 1'b1; kind <= K_CONV; more <= 1'b1; end
              K_CONV: begin
                res_valid <= 1'b1;
                res_data  <= sh[RES_W-1:0];
                res_flag  <= sh[RES_W];
                res_chan  <= chan_q;
                kind      <= K_PD;
                more      <= sleep_q;
              end
              default: begin awake <= 1'b0; more <= 1'b0; end
            endcase
          end else begin
            adc_sclk <= 1'b0;
            cyc      <= cyc + 1'b1;
            tmr      <= half_len;
            st       <= S_LOW;
            if (kind == K_DUMMY && cyc == CW'(1)) adc_chsel <= chan_q;
          end
        end else tmr <= tmr - 1'b1;
        S_GAP: if (tmr_done) begin
          if (more) begin
            adc_cs_n <= 1'b0;
            cyc      <= '0;
            tmr      <= setup_len;
            st       <= S_SETUP;
          end else st <= S_IDLE;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_sequencer_chk.sv
module adc_frame_sequencer_chk #(
  parameter int RES_W  = 12,
  parameter int PD_CYC = 4,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_cs_n,
  input logic          adc_sclk,
  input logic          adc_chsel,
  input logic          req_ready,
  input logic          res_valid,
  input logic [CW-1:0] cyc
);
  localparam logic [CW-1:0] CH_LAST = CW'(RES_W);
  localparam logic [CW-1:0] C_SHORT = CW'(RES_W + 2);
  localparam logic [CW-1:0] C_FULL  = CW'(RES_W + 4);
  localparam logic [CW-1:0] C_PD    = CW'(PD_CYC);

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk); // R1
  AST_RESULT_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_cs_n)); // R3
  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R3
  AST_RESULT_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cyc == C_SHORT || cyc == C_FULL)); // R5
  AST_FRAME_END_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> (cyc == C_PD || cyc == C_SHORT || cyc == C_FULL)); // R6
  AST_EARLY_END_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_cs_n) && cyc == C_PD) |-> !res_valid); // R6
  AST_CHSEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_chsel) |-> (!adc_cs_n && cyc >= CW'(2) && cyc <= CH_LAST)); // R8
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_cs_n); // R9
endmodule

bind adc_frame_sequencer adc_frame_sequencer_chk #(
  .RES_W(RES_W), .PD_CYC(PD_CYC), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .adc_chsel(adc_chsel), .req_ready(req_ready), .res_valid(res_valid), .cyc(cyc)
);

// File: tb/test_adc_frame_sequencer.sv
`timescale 1ns/1ps
module test_adc_frame_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_chan = 1'b0, req_short = 1'b0, req_sleep = 1'b0;
  logic [7:0] cfg_half = 8'd2, cfg_setup = 8'd5, cfg_gap = 8'd3;
  logic adc_dout;
  logic req_ready, adc_cs_n, adc_sclk, adc_chsel, res_valid, res_chan, res_flag;
  logic [11:0] res_data;

  always #4 clk = ~clk;

  adc_frame_sequencer i_adc_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_short(req_short), .req_sleep(req_sleep), .cfg_half(cfg_half),
    .cfg_setup(cfg_setup), .cfg_gap(cfg_gap), .adc_dout(adc_dout),
    .req_ready(req_ready), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_chsel(adc_chsel), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_flag(res_flag));

  int total = 0, bad = 0;

  // converter model
  logic [11:0] ain [2];
  logic [11:0] word = 12'h000;
  logic model_awake = 1'b0, mux = 1'b0, lead_one = 1'b0, dbit = 1'b0;
  int falls = 0, frames = 0, last_len = 0;
  assign adc_dout = dbit;

  always @(negedge adc_cs_n) begin
    falls = 0; frames++; dbit = 1'b0;
    word = model_awake ? ain[mux] : 12'hA5A;
  end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    falls++;
    if (falls == 1) dbit = lead_one;
    else if (falls <= 13) dbit = word[13-falls];
    else dbit = 1'b0;
    if (falls == 12) mux = adc_chsel;
  end
  always @(posedge adc_cs_n) begin
    last_len = falls;
    model_awake = (falls >= 10);
  end

  // timing monitor
  int hi_run = 0, run = 0, gap_bad = 0, setup_bad = 0, half_bad = 0, chsel_bad = 0;
  bit started = 0, seen_fall = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_chsel = 1'b0;
  int e_half, e_setup, e_gap;
  always @(negedge clk) if (rst_n) begin
    e_half  = (cfg_half == 0) ? 1 : int'(cfg_half);
    e_setup = (int'(cfg_setup) > e_half) ? int'(cfg_setup) : e_half;
    e_gap   = (cfg_gap == 0) ? 1 : int'(cfg_gap);
    if (adc_cs_n) begin
      hi_run++;
    end else if (prev_cs) begin
      if (started && hi_run < e_gap) gap_bad++;
      started = 1; hi_run = 0; run = 1; seen_fall = 0;
    end else if (adc_sclk != prev_sclk) begin
      if (!seen_fall) begin
        if (run < e_setup) setup_bad++;
        seen_fall = 1;
      end else if (run != e_half) half_bad++;
      run = 1;
    end else run++;
    if (adc_chsel != prev_chsel && (adc_cs_n || falls < 2 || falls > 12)) chsel_bad++;
    prev_cs = adc_cs_n; prev_sclk = adc_sclk; prev_chsel = adc_chsel;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic run_vec(input logic ch, input logic sh, input logic sl,
                         input logic [11:0] v, input int nfr);
    int f0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ain[ch] = v; ain[ch ^ 1'b1] = ~v;
    f0 = frames;
    req_valid = 1'b1; req_chan = ch; req_short = sh; req_sleep = sl;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
    while (!res_valid) @(negedge clk);
    chk(res_data == v, "R2 result data", int'(res_data), int'(v));
    chk(res_chan == ch, "R3 channel tag", int'(res_chan), int'(ch));
    chk(res_flag == lead_one, "R4 leading bit flag", int'(res_flag), int'(lead_one));
    chk(last_len == (sh ? 14 : 16), "R5 conversion frame length", last_len, sh ? 14 : 16);
    @(negedge clk);
    chk(res_valid == 1'b0, "R3 single-cycle strobe", int'(res_valid), 0);
    while (!req_ready) @(negedge clk);
    chk(frames - f0 == nfr, "R7/R8 frames per request", frames - f0, nfr);
    chk(model_awake == !sl, "R6 converter power state", int'(model_awake), int'(!sl));
    if (sl) chk(last_len == 4, "R6 power-down frame length", last_len, 4);
  endtask

  // {chan, short, sleep, frames[2:0], value[11:0]}
  localparam logic [17:0] VEC [9] = '{
    {1'b0, 1'b0, 1'b0, 3'd2, 12'h5C3},
    {1'b0, 1'b0, 1'b0, 3'd1, 12'hFFF},
    {1'b1, 1'b0, 1'b0, 3'd2, 12'h000},
    {1'b1, 1'b1, 1'b0, 3'd1, 12'h801},
    {1'b1, 1'b1, 1'b1, 3'd2, 12'h7FE},
    {1'b0, 1'b0, 1'b0, 3'd2, 12'h3A5},
    {1'b0, 1'b1, 1'b1, 3'd2, 12'h001},
    {1'b1, 1'b0, 1'b1, 3'd3, 12'hC3C},
    {1'b1, 1'b0, 1'b0, 3'd2, 12'hAAA}
  };

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", wd, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ain[0] = 12'h000; ain[1] = 12'h000;
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 reset select high", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b1, "R1 reset clock high", int'(adc_sclk), 1);
    chk(res_valid == 1'b0, "R1 reset no result", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    for (int i = 0; i < 9; i++)
      run_vec(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][11:0], int'(VEC[i][14:12]));

    // tightest timing, converter asleep after last vector? no: awake on ch1
    cfg_half = 8'd0; cfg_setup = 8'd0; cfg_gap = 8'd0;
    repeat (10) @(negedge clk);
    run_vec(1'b1, 1'b0, 1'b0, 12'h123, 1);
    run_vec(1'b0, 1'b1, 1'b0, 12'hEDC, 2);

    // bad leading bit
    lead_one = 1'b1;
    run_vec(1'b0, 1'b0, 1'b0, 12'h456, 1);
    lead_one = 1'b0;

    // slow clock, long setup and gap
    cfg_half = 8'd3; cfg_setup = 8'd9; cfg_gap = 8'd7;
    repeat (10) @(negedge clk);
    run_vec(1'b1, 1'b1, 1'b1, 12'h9B2, 3);
    run_vec(1'b1, 1'b0, 1'b0, 12'h36D, 2);

    chk(half_bad == 0, "R10 serial clock phase length", half_bad, 0);
    chk(setup_bad == 0, "R10 select to first clock edge", setup_bad, 0);
    chk(gap_bad == 0, "R11 select high between frames", gap_bad, 0);
    chk(chsel_bad == 0, "R8 channel select window", chsel_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule